// File: doc/BRIEF.md
# Configuration Control Sequencer

This block decides when a programmable device starts, holds off, runs and finishes loading its configuration. It watches an active-low program request pin, a shared open-drain init line, a mode-select bus and a few status strobes from the loading engines. From these it drives the init line low, drives the done line low, issues a memory-clear command, latches the selected configuration port and pulses a start strobe to the chosen loader.

The init line is a shared handshake. The sequencer pulls it low while it clears the configuration memory. Any outside agent can keep it low to postpone loading. The sequencer pulls it low again to report a load error. Each pad is modelled as a drive-low enable plus a sampled pin level. The program pin and the init level each pass through a synchroniser before the state machine uses them. The loaders themselves appear only as the `load_start`, `load_done` and `cfg_err` handshakes.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `init_drive_low` and `done_drive_low` are 1, `clear_mem` and `load_start` are 0, and `cfg_mode` is 0.
- R2: In the first cycle after `por_n` rises, the block latches `mode_pins` into `cfg_mode` and enters the clearing phase.
- R3: In the clearing phase, `clear_mem` and `init_drive_low` are both 1. The phase lasts at least `CLR_CYCLES` cycles and continues while the synchronised program request is still low.
- R4: A high-to-low transition of `prog_n_pin`, seen after a two-flop synchroniser, restarts the sequence from any state. The block enters the clearing phase on the third rising edge after the pin falls and relatches `mode_pins`.
- R5: After clearing, the block releases init and waits. `load_start` stays 0 while the synchronised init level reads low. It pulses for one cycle once the level reads high, and loading then begins.
- R6: During loading, a `cfg_err` pulse moves the block to an error state that drives init low.
- R7: The error state is left only by a program-request restart or by power-on reset. `load_done` and `cfg_err` have no effect there.
- R8: During loading, `load_done` moves the block to user mode, where init is released. `cfg_err` is ignored in user mode.
- R9: `done_drive_low` is 0 exactly when `done_bit` is 1 and both the synchronised init level and the synchronised program level are high. Otherwise it is 1.
- R10: While `jtag_active` is 1, program-request falling edges are ignored.
- R11: When `cfg_mode` equals `SPI_CODE` (default 3'b010, the SPI port), program-request falling edges are ignored. Only power-on reset restarts the block.
- R12: `cfg_mode` changes only when the clearing phase is entered (R2, R4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| prog_n_pin | input | 1 | Program request pin level, active low |
| init_pin | input | 1 | Sampled level of the shared open-drain init line |
| mode_pins | input | MODE_W | Configuration mode select |
| jtag_active | input | 1 | The boundary-scan port owns the device |
| cfg_err | input | 1 | Load error strobe from the loader |
| load_done | input | 1 | Load complete strobe from the loader |
| done_bit | input | 1 | Internal done bit is programmed |
| init_drive_low | output | 1 | Pull the init line low |
| done_drive_low | output | 1 | Pull the done line low |
| clear_mem | output | 1 | Clear configuration memory |
| cfg_mode | output | MODE_W | Latched configuration mode |
| load_start | output | 1 | One-cycle start strobe to the selected loader |

## Verification
Some properties hold on every cycle, and the assertions check those:
- clearing implies init is driven;
- the error state keeps init low and only exits into clearing;
- the start strobe never coincides with driving init;
- a restart never happens while JTAG is active or from user mode in SPI mode;
- the latched mode moves only on entry to clearing.

Other behaviour depends on sequences of stimulus, and only the bench's scenarios can show it:
- the external hold-off of init;
- the minimum clear length while the program request is held low;
- relatching of new mode values;
- recovery from the error state through a program pulse and through power-on reset.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_CLEAR = 3'd1,
    ST_WAIT  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_ERROR = 3'd4,
    ST_USER  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_clr_timer.sv
module cfg_clr_timer #(
  parameter int CLR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CLR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CLR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == LAST);
  assign cnt_en  = restart || (run && !expired);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int          CLR_CYCLES  = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          MODE_W      = 3,
  parameter int unsigned SPI_CODE    = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              prog_n_pin,
  input  logic              init_pin,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              jtag_active,
  input  logic              cfg_err,
  input  logic              load_done,
  input  logic              done_bit,
  output logic              init_drive_low,
  output logic              done_drive_low,
  output logic              clear_mem,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              load_start
);
  localparam logic [MODE_W-1:0] SPI_SEL = MODE_W'(SPI_CODE);

  seq_state_e        state_q, state_d;
  logic [MODE_W-1:0] mode_q;
  logic              mode_en;
  logic              prog_s, init_s, prog_prev_q;
  logic              prog_fall, restart;
  logic              clr_restart, clr_expired;

  cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_prog_sync (
    .clk(clk), .rst_n(por_n), .d(prog_n_pin), .q(prog_s));

  cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_init_sync (
    .clk(clk), .rst_n(por_n), .d(init_pin), .q(init_s));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) prog_prev_q <= 1'b1;
    else        prog_prev_q <= prog_s;
  end

  assign prog_fall = prog_prev_q && !prog_s;
  assign restart   = prog_fall && !jtag_active && (mode_q != SPI_SEL);

  // next-state process
  always_comb begin
    state_d = state_q;
    if (state_q == ST_RESET || restart) begin
      state_d = ST_CLEAR;
    end else begin
      unique case (state_q)
        ST_CLEAR: if (clr_expired && prog_s) state_d = ST_WAIT;
        ST_WAIT:  if (init_s)                state_d = ST_LOAD;
        ST_LOAD: begin
          if (cfg_err)        state_d = ST_ERROR;
          else if (load_done) state_d = ST_USER;
        end
        default: state_d = state_q;
      endcase
    end
  end

  assign mode_en     = (state_q == ST_RESET) || restart;
  assign clr_restart = mode_en;

  cfg_clr_timer #(.CLR_CYCLES(CLR_CYCLES)) u_clr_timer (
    .clk(clk), .rst_n(por_n), .restart(clr_restart),
    .run(state_q == ST_CLEAR), .expired(clr_expired));

  // register process
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_pins;
  end

  assign init_drive_low = (state_q == ST_RESET) || (state_q == ST_CLEAR) ||
                          (state_q == ST_ERROR);
  assign clear_mem      = (state_q == ST_CLEAR);
  assign load_start     = (state_q == ST_WAIT) && init_s && !restart;
  assign done_drive_low = !(done_bit && init_s && prog_s);
  assign cfg_mode       = mode_q;
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk
  import cfg_seq_pkg::*;
#(
  parameter int          MODE_W   = 3,
  parameter int unsigned SPI_CODE = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              jtag_active,
  input logic              init_drive_low,
  input logic              clear_mem,
  input logic              load_start,
  input logic [MODE_W-1:0] cfg_mode,
  input seq_state_e        state_q
);
  // R3: clearing always holds the init line low
  assert_clear_drives_init_R3: assert property (@(posedge clk) disable iff (!por_n)
    clear_mem |-> init_drive_low);

  // R5: the loader never starts while the block still drives init
  assert_start_with_init_released_R5: assert property (@(posedge clk) disable iff (!por_n)
    load_start |-> !init_drive_low);

  // R6: the error state flags on init
  assert_error_drives_init_R6: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_ERROR) |-> init_drive_low);

  // R7: the error state can only exit into clearing
  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_ERROR) |=> (state_q == ST_ERROR || state_q == ST_CLEAR));

  // R10: no restart out of user mode while the boundary-scan port is active
  assert_jtag_blocks_restart_R10: assert property (@(posedge clk) disable iff (!por_n)
    (jtag_active && state_q == ST_USER) |=> (state_q == ST_USER));

  // R11: in SPI mode, user mode is left only by power-on reset
  assert_spi_no_restart_R11: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_mode == MODE_W'(SPI_CODE) && state_q == ST_USER) |=> (state_q == ST_USER));

  // R12: the latched mode moves only when clearing begins
  assert_mode_moves_on_clear_R12: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(cfg_mode) |-> (state_q == ST_CLEAR));
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.MODE_W(MODE_W), .SPI_CODE(SPI_CODE)) u_seq_chk (
  .clk(clk), .por_n(por_n), .jtag_active(jtag_active),
  .init_drive_low(init_drive_low), .clear_mem(clear_mem),
  .load_start(load_start), .cfg_mode(cfg_mode), .state_q(state_q));

// File: tb/test_cfg_seq_ctrl.sv
`timescale 1ns/1ps
module test_cfg_seq_ctrl;
  localparam int CLR = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_n = 1'b1;
  logic       ext_hold = 1'b0;
  logic [2:0] mode_pins = 3'd1;
  logic       jtag = 1'b0, err = 1'b0, ldone = 1'b0, dbit = 1'b0;
  logic       init_low, done_low, clr, lstart;
  logic [2:0] mode;
  logic       init_level;

  int checks = 0, fails = 0;

  assign init_level = !(init_low || ext_hold);
  always #4 clk = ~clk;

  cfg_seq_ctrl #(.CLR_CYCLES(CLR)) i_cfg_seq_ctrl (
    .clk(clk), .por_n(rst_n), .prog_n_pin(prog_n), .init_pin(init_level),
    .mode_pins(mode_pins), .jtag_active(jtag), .cfg_err(err), .load_done(ldone),
    .done_bit(dbit), .init_drive_low(init_low), .done_drive_low(done_low),
    .clear_mem(clr), .cfg_mode(mode), .load_start(lstart));

  // behavioural reference: phase 0 reset,1 clear,2 wait,3 load,4 error,5 user
  int   m_ph = 0, m_cnt = 0;
  int   m_mode = 0;
  bit   m_pin_q[$] = '{1, 1};
  bit   m_prev = 1;
  bit   m_ini_q[$] = '{0, 0};

  function automatic bit m_prog();  return m_pin_q[1]; endfunction
  function automatic bit m_init();  return m_ini_q[1]; endfunction
  function automatic bit m_go();
    return m_prev && !m_prog() && !jtag && (m_mode != 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_mode = 0; m_prev = 1;
      m_pin_q = '{1, 1}; m_ini_q = '{0, 0};
    end else begin
      int nph = m_ph;
      int ncnt = m_cnt;
      if (m_ph == 1 && m_cnt < CLR - 1) ncnt = m_cnt + 1;
      if (m_ph == 0 || m_go()) begin
        nph = 1; ncnt = 0; m_mode = mode_pins;
      end else if (m_ph == 1) begin
        if (m_cnt == CLR - 1 && m_prog()) nph = 2;
      end else if (m_ph == 2) begin
        if (m_init()) nph = 3;
      end else if (m_ph == 3) begin
        if (err) nph = 4;
        else if (ldone) nph = 5;
      end
      m_prev = m_prog();
      m_pin_q.push_front(prog_n);   void'(m_pin_q.pop_back());
      m_ini_q.push_front(init_level); void'(m_ini_q.pop_back());
      m_ph = nph; m_cnt = ncnt;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit e_init, e_clr, e_ls, e_done;
    e_init = (m_ph == 0 || m_ph == 1 || m_ph == 4);
    e_clr  = (m_ph == 1);
    e_ls   = (m_ph == 2) && m_init() && !m_go();
    e_done = !(dbit && m_init() && m_prog());
    chk(init_low == e_init, "R3 init_drive_low", init_low, e_init);
    chk(clr == e_clr, "R3 clear_mem", clr, e_clr);
    chk(lstart == e_ls, "R5 load_start", lstart, e_ls);
    chk(done_low == e_done, "R9 done_drive_low", done_low, e_done);
    chk(mode == 3'(m_mode), "R12 cfg_mode", mode, m_mode);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic prog_pulse(input int low_cycles);
    prog_n = 1'b0; cyc(low_cycles); prog_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    cyc(4);
    chk(init_low && done_low && !clr && !lstart && mode == 0, "R1 reset outputs",
        {init_low, done_low, clr, lstart}, 4'b1100);
    ext_hold = 1'b1;
    rst_n = 1'b1;
    cyc(3);
    chk(clr == 1 && mode == 1, "R2 clear with latched mode", mode, 1);
    cyc(40);
    chk(!clr && !init_low && !lstart, "R5 held off by external init", lstart, 0);
    ext_hold = 1'b0;
    cyc(6);
    chk(!init_low && !clr, "R5 loading after init high", init_low, 0);
    ldone = 1'b1; cyc(1); ldone = 1'b0;
    dbit = 1'b1; cyc(2);
    chk(done_low == 0, "R9 done released in user mode", done_low, 0);
    err = 1'b1; cyc(1); err = 1'b0; cyc(3);
    chk(init_low == 0, "R8 error ignored in user mode", init_low, 0);
    mode_pins = 3'd4;
    prog_n = 1'b0; cyc(30);
    chk(clr == 1, "R3 clear held while prog low", clr, 1);
    chk(mode == 4, "R4 mode relatched on restart", mode, 4);
    prog_n = 1'b1; cyc(30);
    err = 1'b1; cyc(1); err = 1'b0; cyc(2);
    chk(init_low == 1, "R6 error drives init", init_low, 1);
    ldone = 1'b1; cyc(1); ldone = 1'b0; cyc(5);
    chk(init_low == 1 && !clr, "R7 error sticky", init_low, 1);
    mode_pins = 3'd3;
    prog_pulse(3); cyc(3);
    chk(clr == 1, "R4 restart out of error", clr, 1);
    cyc(40);
    ldone = 1'b1; cyc(1); ldone = 1'b0; cyc(2);
    jtag = 1'b1;
    prog_pulse(4); cyc(6);
    chk(clr == 0 && init_low == 0, "R10 program ignored under jtag", clr, 0);
    jtag = 1'b0; cyc(2);
    mode_pins = 3'd2;
    prog_pulse(3); cyc(3);
    chk(clr == 1 && mode == 2, "R4 restart into SPI mode", mode, 2);
    cyc(40);
    ldone = 1'b1; cyc(1); ldone = 1'b0; cyc(2);
    mode_pins = 3'd6;
    prog_pulse(3); cyc(6);
    chk(clr == 0 && mode == 2, "R11 program ignored in SPI mode", mode, 2);
    rst_n = 1'b0; cyc(3);
    chk(init_low && done_low && !clr && mode == 0, "R1 reset again", mode, 0);
    mode_pins = 3'd5;
    rst_n = 1'b1; cyc(3);
    chk(clr == 1 && mode == 5, "R2 power cycle leaves SPI mode", mode, 5);
    cyc(5);
    finish_run();
  end
endmodule